// File: doc/BRIEF.md
# Memory Self-Test Failure Logger

This block sits beside the compare stage of a memory built-in self-test engine. Each cycle the engine presents a read word, the word it expected, a mask of read bits that are not implemented, the index of the array under test, the physical address, the pattern code, the algorithm pass number and the data seed in use, all qualified by a compare-valid strobe. The logger turns miscompares into a fail output and keeps enough state for a host to diagnose the run afterwards.

Two kinds of record are kept. A per-array failure mask accumulates over the whole run, and a paired set of arrays that are exercised together marks both of its bits on a failure in either one. A snapshot of the very first failure freezes the seed, address, pass, pattern and the failing bit vector. The failing bit vector is reduced to one 33-bit half of the 65-bit read bus, and a half flag records which half it is. The fail output runs in one of two modes. In real-time mode it follows each miscompare. In sticky mode it latches on the first miscompare and holds until the log is cleared.

Top module: `mbist_fail_log`

## Requirements
- R1: After reset, failOut, failMask, snapValid and every snapshot field read 0, and the mode bit is 0 (sticky mode).
- R2: A miscompare is any set bit of (rdData XOR expData) with unused bits removed. If any such bit lies in bits 31:0, snapHalf is 0 and snapBits is {1'b0, bits 31:0}. Otherwise snapHalf is 1 and snapBits holds bits 64:32.
- R3: A read bit whose unusedMask bit is 1 never causes a failure, whatever its data.
- R4: With the mode bit at 1, failOut is 1 in exactly the cycles that follow a valid miscompare, and 0 after any other cycle.
- R5: With the mode bit at 0, failOut rises in the cycle after the first valid miscompare and stays 1 until clearLog.
- R6: On a valid miscompare, failMask bit arrayIdx becomes 1. Mask bits never fall except on clearLog.
- R7: When pairParallel is 1 and arrayIdx equals either PAIR_A or PAIR_B (defaults 3 and 4), a miscompare sets both of those mask bits.
- R8: On the first miscompare since reset or clear, snapValid becomes 1, and snapSeed, snapAddr, snapPass and snapPattern take that cycle's seed, failAddr, passNum and patternCode.
- R9: Later miscompares leave every snapshot field and snapValid unchanged.
- R10: clearLog zeroes failMask, the snapshot and the sticky flag on the next edge. It overrides a miscompare in the same cycle, and that miscompare also produces no real-time pulse.
- R11: With cmpValid at 0, differing data changes no output in the next cycle.
- R12: cfgWe loads cfgRtFail into the mode bit. The new mode selects failOut from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Load strobe for the mode bit |
| cfgRtFail | input | 1 | Mode value: 1 real-time, 0 sticky |
| clearLog | input | 1 | Clears mask, snapshot and sticky flag |
| cmpValid | input | 1 | Qualifies this cycle's compare |
| rdData | input | 65 | Data read from the array |
| expData | input | 65 | Expected data |
| unusedMask | input | 65 | 1 marks a read bit that is not implemented |
| arrayIdx | input | 3 | Array under test |
| pairParallel | input | 1 | The paired arrays are being tested together |
| failAddr | input | 17 | Physical address of the access |
| patternCode | input | 6 | Running pattern code |
| passNum | input | 4 | Algorithm pass, counted from 1 |
| seed | input | 4 | Data seed currently applied |
| failOut | output | 1 | Fail indication |
| failMask | output | 8 | One bit per array that has failed |
| snapValid | output | 1 | A first failure has been captured |
| snapSeed | output | 4 | Seed at the first failure |
| snapAddr | output | 17 | Address at the first failure |
| snapBits | output | 33 | Failing bits of the selected half |
| snapHalf | output | 1 | 0: bits 31:0, 1: bits 64:32 |
| snapPass | output | 4 | Pass number at the first failure |
| snapPattern | output | 6 | Pattern code at the first failure |

## Verification
Every piece of internal state reaches a port one edge after the cycle that should change it. A wrong sticky flag shows on failOut in sticky mode, and a lost or spurious strobe shows as a missing or extra mask bit or a snapshot that moves. The bench therefore compares every output against its own model at each cycle, so the first bad cycle is reported at once. Directed cycles cover half selection, masked bits, pairing, clear-versus-miss collisions and mode changes.

// File: rtl/mbist_log_pkg.sv
package mbist_log_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic hit;    // qualified miscompare this cycle
    logic first;  // hit with no snapshot held yet
    logic wipe;   // clear the log
  } logStrobe_t;

endpackage

// File: rtl/mbist_log_dp.sv
module mbist_log_dp
  import mbist_log_pkg::*;
#(
  parameter int NUM_ARRAYS = 8,
  parameter int DATA_W     = 65,
  parameter int LO_W       = 32,
  parameter int ADDR_W     = 17,
  parameter int SEED_W     = 4,
  parameter int PASS_W     = 4,
  parameter int PAT_W      = 6,
  parameter int PAIR_A     = 3,
  parameter int PAIR_B     = 4,
  localparam int IDX_W     = $clog2(NUM_ARRAYS),
  localparam int HI_W      = DATA_W - LO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] expData,
  input  logic [DATA_W-1:0] unusedMask,
  input  logic [IDX_W-1:0]  arrayIdx,
  input  logic              pairParallel,
  input  logic [ADDR_W-1:0] failAddr,
  input  logic [PAT_W-1:0]  patternCode,
  input  logic [PASS_W-1:0] passNum,
  input  logic [SEED_W-1:0] seed,
  input  logStrobe_t        strobe,
  output logic              anyMiss,
  output logic [NUM_ARRAYS-1:0] failMask,
  output logic              snapValid,
  output logic [SEED_W-1:0] snapSeed,
  output logic [ADDR_W-1:0] snapAddr,
  output logic [HI_W-1:0]   snapBits,
  output logic              snapHalf,
  output logic [PASS_W-1:0] snapPass,
  output logic [PAT_W-1:0]  snapPattern
);

  logic [DATA_W-1:0]     missVec;
  logic                  loMiss;
  logic [HI_W-1:0]       selBits;
  logic [NUM_ARRAYS-1:0] setVec;
  logic                  idxIsPair;

  assign missVec   = (rdData ^ expData) & ~unusedMask;
  assign loMiss    = |missVec[LO_W-1:0];
  assign anyMiss   = |missVec;
  assign selBits   = loMiss ? {{(HI_W-LO_W){1'b0}}, missVec[LO_W-1:0]}
                            : missVec[DATA_W-1:LO_W];
  assign idxIsPair = (arrayIdx == IDX_W'(PAIR_A)) || (arrayIdx == IDX_W'(PAIR_B));

  for (genvar gi = 0; gi < NUM_ARRAYS; gi++) begin : g_set
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
    localparam bit IN_PAIR = (gi == PAIR_A) || (gi == PAIR_B);
    if (IN_PAIR) begin : g_pair
      assign setVec[gi] = (arrayIdx == MY_IDX) || (pairParallel && idxIsPair);
    end else begin : g_single
      assign setVec[gi] = (arrayIdx == MY_IDX);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failMask <= '0;
    end else if (strobe.wipe) begin
      failMask <= '0;
    end else if (strobe.hit) begin
      failMask <= failMask | setVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapValid   <= 1'b0;
      snapSeed    <= '0;
      snapAddr    <= '0;
      snapBits    <= '0;
      snapHalf    <= 1'b0;
      snapPass    <= '0;
      snapPattern <= '0;
    end else if (strobe.wipe) begin
      snapValid   <= 1'b0;
      snapSeed    <= '0;
      snapAddr    <= '0;
      snapBits    <= '0;
      snapHalf    <= 1'b0;
      snapPass    <= '0;
      snapPattern <= '0;
    end else if (strobe.first) begin
      snapValid   <= 1'b1;
      snapSeed    <= seed;
      snapAddr    <= failAddr;
      snapBits    <= selBits;
      snapHalf    <= ~loMiss;
      snapPass    <= passNum;
      snapPattern <= patternCode;
    end
  end

  // R6: mask bits only rise unless a clear is applied
  p_mask_grows_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wipe |=> ((failMask & $past(failMask)) == $past(failMask)));

  // R9: a held snapshot does not move
  p_snap_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (snapValid && !strobe.wipe) |=> (snapValid && $stable(snapAddr) && $stable(snapBits)
      && $stable(snapSeed) && $stable(snapPass) && $stable(snapPattern) && $stable(snapHalf)));

  // R10: clear empties the log
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipe |=> (failMask == '0 && !snapValid));

  // R8: a first hit always yields a snapshot
  p_first_captures_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.first |=> snapValid);

endmodule

// File: rtl/mbist_log_ctrl.sv
module mbist_log_ctrl
  import mbist_log_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       cfgRtFail,
  input  logic       clearLog,
  input  logic       cmpValid,
  input  logic       anyMiss,
  input  logic       snapValid,
  output logStrobe_t strobe,
  output logic       failOut
);

  logic rtMode;
  logic hitQ;
  logic stickyQ;

  always_comb begin
    strobe.wipe  = clearLog;
    strobe.hit   = cmpValid && anyMiss && !clearLog;
    strobe.first = strobe.hit && !snapValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtMode <= 1'b0;
    end else if (cfgWe) begin
      rtMode <= cfgRtFail;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ    <= 1'b0;
      stickyQ <= 1'b0;
    end else begin
      hitQ <= strobe.hit;
      if (strobe.wipe) begin
        stickyQ <= 1'b0;
      end else if (strobe.hit) begin
        stickyQ <= 1'b1;
      end
    end
  end

  assign failOut = rtMode ? hitQ : stickyQ;

  // R4: in real-time mode a hit gives a pulse, no hit gives none
  p_rt_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rtMode && !cfgWe && strobe.hit) |=> failOut);
  p_rt_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rtMode && !cfgWe && !strobe.hit) |=> !failOut);

  // R5: sticky fail holds until cleared
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rtMode && !cfgWe && failOut && !clearLog) |=> failOut);

  // R11: an unqualified cycle produces no hit
  p_idle_nohit_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid |-> !strobe.hit);

endmodule

// File: rtl/mbist_fail_log.sv
module mbist_fail_log
  import mbist_log_pkg::*;
#(
  parameter int NUM_ARRAYS = 8,
  parameter int DATA_W     = 65,
  parameter int LO_W       = 32,
  parameter int ADDR_W     = 17,
  parameter int SEED_W     = 4,
  parameter int PASS_W     = 4,
  parameter int PAT_W      = 6,
  parameter int PAIR_A     = 3,
  parameter int PAIR_B     = 4,
  localparam int IDX_W     = $clog2(NUM_ARRAYS),
  localparam int HI_W      = DATA_W - LO_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic                  cfgRtFail,
  input  logic                  clearLog,
  input  logic                  cmpValid,
  input  logic [DATA_W-1:0]     rdData,
  input  logic [DATA_W-1:0]     expData,
  input  logic [DATA_W-1:0]     unusedMask,
  input  logic [IDX_W-1:0]      arrayIdx,
  input  logic                  pairParallel,
  input  logic [ADDR_W-1:0]     failAddr,
  input  logic [PAT_W-1:0]      patternCode,
  input  logic [PASS_W-1:0]     passNum,
  input  logic [SEED_W-1:0]     seed,
  output logic                  failOut,
  output logic [NUM_ARRAYS-1:0] failMask,
  output logic                  snapValid,
  output logic [SEED_W-1:0]     snapSeed,
  output logic [ADDR_W-1:0]     snapAddr,
  output logic [HI_W-1:0]       snapBits,
  output logic                  snapHalf,
  output logic [PASS_W-1:0]     snapPass,
  output logic [PAT_W-1:0]      snapPattern
);

  logStrobe_t strobe;
  logic       anyMiss;

  mbist_log_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgRtFail (cfgRtFail),
    .clearLog  (clearLog),
    .cmpValid  (cmpValid),
    .anyMiss   (anyMiss),
    .snapValid (snapValid),
    .strobe    (strobe),
    .failOut   (failOut)
  );

  mbist_log_dp #(
    .NUM_ARRAYS (NUM_ARRAYS),
    .DATA_W     (DATA_W),
    .LO_W       (LO_W),
    .ADDR_W     (ADDR_W),
    .SEED_W     (SEED_W),
    .PASS_W     (PASS_W),
    .PAT_W      (PAT_W),
    .PAIR_A     (PAIR_A),
    .PAIR_B     (PAIR_B)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .rdData       (rdData),
    .expData      (expData),
    .unusedMask   (unusedMask),
    .arrayIdx     (arrayIdx),
    .pairParallel (pairParallel),
    .failAddr     (failAddr),
    .patternCode  (patternCode),
    .passNum      (passNum),
    .seed         (seed),
    .strobe       (strobe),
    .anyMiss      (anyMiss),
    .failMask     (failMask),
    .snapValid    (snapValid),
    .snapSeed     (snapSeed),
    .snapAddr     (snapAddr),
    .snapBits     (snapBits),
    .snapHalf     (snapHalf),
    .snapPass     (snapPass),
    .snapPattern  (snapPattern)
  );

endmodule

// File: tb/sim_mbist_fail_log.sv
`timescale 1ns/1ps
module sim_mbist_fail_log;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 0, cfgRtFail = 0, clearLog = 0, cmpValid = 0, pairParallel = 0;
  logic [64:0] rdData = '0, expData = '0, unusedMask = '0;
  logic [2:0]  arrayIdx = '0;
  logic [16:0] failAddr = '0;
  logic [5:0]  patternCode = '0;
  logic [3:0]  passNum = '0, seed = '0;
  logic        failOut, snapValid, snapHalf;
  logic [7:0]  failMask;
  logic [3:0]  snapSeed, snapPass;
  logic [16:0] snapAddr;
  logic [32:0] snapBits;
  logic [5:0]  snapPattern;

  int nChecks = 0, nFails = 0;

  // reference model state
  bit          mRt = 0, mHit = 0, mSticky = 0, mSnapV = 0, mHalf = 0;
  logic [7:0]  mMask = '0;
  logic [3:0]  mSeed = '0, mPass = '0;
  logic [16:0] mAddr = '0;
  logic [32:0] mBits = '0;
  logic [5:0]  mPat = '0;

  always #4 clk = ~clk;

  mbist_fail_log u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRtFail(cfgRtFail), .clearLog(clearLog),
    .cmpValid(cmpValid), .rdData(rdData), .expData(expData), .unusedMask(unusedMask),
    .arrayIdx(arrayIdx), .pairParallel(pairParallel), .failAddr(failAddr),
    .patternCode(patternCode), .passNum(passNum), .seed(seed), .failOut(failOut),
    .failMask(failMask), .snapValid(snapValid), .snapSeed(snapSeed), .snapAddr(snapAddr),
    .snapBits(snapBits), .snapHalf(snapHalf), .snapPass(snapPass), .snapPattern(snapPattern)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // model of one clock edge using the inputs now applied
  task automatic modelEdge();
    logic [64:0] mv;
    bit miss;
    mv   = (rdData ^ expData) & ~unusedMask;
    miss = cmpValid && (mv != '0);
    if (cfgWe) mRt = cfgRtFail;
    mHit = miss && !clearLog;
    if (clearLog) begin
      mMask = '0; mSnapV = 0; mSticky = 0; mHalf = 0;
      mSeed = '0; mPass = '0; mAddr = '0; mBits = '0; mPat = '0;
    end else if (miss) begin
      mMask[arrayIdx] = 1'b1;
      if (pairParallel && (arrayIdx == 3'd3 || arrayIdx == 3'd4)) begin
        mMask[3] = 1'b1; mMask[4] = 1'b1;
      end
      mSticky = 1;
      if (!mSnapV) begin
        mSnapV = 1; mSeed = seed; mAddr = failAddr; mPass = passNum; mPat = patternCode;
        if (|mv[31:0]) begin mHalf = 0; mBits = {1'b0, mv[31:0]}; end
        else begin mHalf = 1; mBits = mv[64:32]; end
      end
    end
  endtask

  task automatic checkAll(string req);
    chk(req, "failOut", 64'(failOut), 64'(mRt ? mHit : mSticky));
    chk(req, "failMask", 64'(failMask), 64'(mMask));
    chk(req, "snapValid", 64'(snapValid), 64'(mSnapV));
    chk(req, "snapSeed", 64'(snapSeed), 64'(mSeed));
    chk(req, "snapAddr", 64'(snapAddr), 64'(mAddr));
    chk(req, "snapBits", 64'(snapBits), 64'(mBits));
    chk(req, "snapHalf", 64'(snapHalf), 64'(mHalf));
    chk(req, "snapPass", 64'(snapPass), 64'(mPass));
    chk(req, "snapPattern", 64'(snapPattern), 64'(mPat));
  endtask

  // inputs are applied after a falling edge; results checked at the next falling edge
  task automatic cyc(string req);
    modelEdge();
    @(negedge clk);
    checkAll(req);
  endtask

  task automatic setCmp(bit v, logic [64:0] rd, logic [64:0] ex, logic [64:0] um,
                        logic [2:0] idx, bit par);
    cmpValid = v; rdData = rd; expData = ex; unusedMask = um;
    arrayIdx = idx; pairParallel = par;
    failAddr = 17'($urandom); patternCode = 6'($urandom);
    passNum = 4'($urandom); seed = 4'($urandom);
    cfgWe = 0; clearLog = 0;
  endtask

  initial begin
    logic [64:0] base;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    chk("R1", "failOut", 64'(failOut), 64'd0);

    base = {1'b1, $urandom, $urandom};
    // R11: invalid compare with differing data
    setCmp(0, base, ~base, '0, 3'd2, 0); cyc("R11");
    chk("R11", "mask idle", 64'(failMask), 64'd0);
    // R3: difference only in unused bits
    setCmp(1, base, base ^ 65'h1_0000_0000_0000_0010, 65'h1_0000_0000_0000_0010, 3'd1, 0); cyc("R3");
    chk("R3", "mask masked", 64'(failMask), 64'd0);
    // R2/R8: high-half only miss, sticky mode
    setCmp(1, base, base ^ (65'd1 << 40), '0, 3'd6, 0); cyc("R8");
    chk("R2", "half high", 64'(snapHalf), 64'd1);
    chk("R2", "bits high", 64'(snapBits), 64'(33'd1 << 8));
    // R9: a later miss in low half keeps the snapshot
    setCmp(1, base, base ^ 65'h5, '0, 3'd0, 0); cyc("R9");
    chk("R9", "half kept", 64'(snapHalf), 64'd1);
    // R5: sticky stays after clean cycles
    setCmp(1, base, base, '0, 3'd0, 0); cyc("R5");
    chk("R5", "sticky", 64'(failOut), 64'd1);
    // R10: clear together with a miss
    setCmp(1, base, ~base, '0, 3'd7, 0); clearLog = 1; cyc("R10");
    chk("R10", "mask cleared", 64'(failMask), 64'd0);
    chk("R10", "fail cleared", 64'(failOut), 64'd0);
    // R2: miss in both halves picks low half
    setCmp(1, base, base ^ {1'b1, 32'h0, 32'h8000_0001}, '0, 3'd3, 1); cyc("R7");
    chk("R2", "half low", 64'(snapHalf), 64'd0);
    chk("R2", "bits low", 64'(snapBits), 64'h8000_0001);
    chk("R7", "pair both", 64'(failMask), 64'h18);
    // R7: pair not parallel sets one bit only
    setCmp(0, base, base, '0, 3'd0, 0); clearLog = 1; cyc("R10");
    setCmp(1, base, ~base, '0, 3'd4, 0); cyc("R7");
    chk("R7", "pair single", 64'(failMask), 64'h10);
    // R12/R4: switch to real-time mode, pulses follow misses
    setCmp(0, base, base, '0, 3'd0, 0); cfgWe = 1; cfgRtFail = 1; cyc("R12");
    chk("R12", "rt quiet", 64'(failOut), 64'd0);
    setCmp(1, base, ~base, '0, 3'd5, 0); cyc("R4");
    chk("R4", "rt pulse", 64'(failOut), 64'd1);
    setCmp(1, base, base, '0, 3'd5, 0); cyc("R4");
    chk("R4", "rt drop", 64'(failOut), 64'd0);
    setCmp(1, base, ~base, '0, 3'd2, 0); clearLog = 1; cyc("R10");
    chk("R10", "no pulse on clear", 64'(failOut), 64'd0);

    // constrained random mix
    for (int i = 0; i < 2000; i++) begin
      logic [64:0] rd, flip, um;
      rd   = 65'({$urandom, $urandom, $urandom});
      flip = ($urandom % 4 == 0) ? (65'd1 << ($urandom % 65)) : '0;
      if ($urandom % 8 == 0) flip = flip | (65'd1 << ($urandom % 65));
      um   = ($urandom % 5 == 0) ? flip : '0;
      setCmp(($urandom % 4) != 0, rd, rd ^ flip, um, 3'($urandom), 1'($urandom));
      clearLog  = ($urandom % 40 == 0);
      cfgWe     = ($urandom % 50 == 0);
      cfgRtFail = 1'($urandom);
      cyc("R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule